// File: doc/BRIEF.md
# Sidepanel and Blanking Inserter

This block sits at the tail of a 4:4:4 video stream, just ahead of the digital-to-analog converters. Each beat carries one luma sample, one pair of signed chroma samples and two timing flags: a horizontal reference and a vertical reference. The block counts beats from the rising edge of the horizontal reference and counts lines from the rising edge of the vertical reference. From those two positions it decides, for every beat, whether to blank it, paint it with a sidepanel colour or pass it through with the selected luma range applied.

Sidepanel edges have a coarse resolution of four beats and a common fine offset of zero to three beats. Blanking is the union of a horizontal window and a vertical window. Each window may wrap around the end of its count. Blanking overrides the sidepanel. The luma path either clips the signed input to the full 10-bit range, or halves it and lifts it to the middle of the range, which leaves headroom for undershoot and overshoot. All settings are sampled on the beat that carries a vertical reference rising edge, so a field never changes its windows partway through.

Both stream edges use valid/ready. An input beat is taken when `s_valid` and `s_ready` are both high. `s_ready` is high whenever the output register is empty or is being drained in the same cycle. A stalled output holds its value. The timing flags travel with the data, so back-pressure never shifts the windows.

Top module: `sbi_top`

## Requirements
- R1: While `rst_n` is low, `m_valid` is 0 and `s_ready` is 1.
- R2: `s_ready` equals `!m_valid || m_ready`. A beat accepted in one cycle appears on `m_*` with `m_valid` high on the next cycle. While `m_valid` is high and `m_ready` is low, `m_valid`, `m_y`, `m_u` and `m_v` hold.
- R3: A beat is a horizontal rising edge when `s_href` is 1 and it was 0 on the previously accepted beat. That beat has position 0. Each later accepted beat has position one higher, and the position holds at its maximum. The line number is 0 on a vertical rising edge beat. Otherwise it increases by one on each horizontal rising edge beat and holds on all other beats.
- R4: Let S = 4·`cfg_sp_start` + `cfg_sp_fine` and E = 4·`cfg_sp_stop` + `cfg_sp_fine`. A beat whose position is below S, or at or above E, is a sidepanel beat. Unless it is also blanked, it outputs Y = `cfg_sp_y`, U = {`cfg_sp_u`, 4'b0000} and V = {`cfg_sp_v`, 4'b0000}.
- R5: A window with set value A and reset value B covers count c as follows. If A ≤ B, it covers A ≤ c < B. If A > B, it covers c ≥ A or c < B. The horizontal window uses the position with `cfg_hb_set`/`cfg_hb_rst`. The vertical window uses the line number with `cfg_vb_set`/`cfg_vb_rst`. A beat is blanked when either window covers it.
- R6: A blanked beat outputs Y = 64, U = 0 and V = 0, whether or not it is in a sidepanel.
- R7: With `cfg_y9` = 0, a passed beat outputs Y = the signed `s_y` clipped to 0..1023.
- R8: With `cfg_y9` = 1, a passed beat outputs Y = floor(`s_y`/2) + 256, clipped to 0..1023.
- R9: A beat that is neither blanked nor in a sidepanel outputs U and V equal to its inputs.
- R10: All `cfg_*` inputs are captured on an accepted vertical rising edge beat and govern that beat and every beat up to the next such beat. Changes at any other time have no effect until then. Before the first capture, every setting is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | display clock |
| rst_n | input | 1 | active-low synchronous reset |
| s_valid | input | 1 | input beat valid |
| s_ready | output | 1 | input beat accepted when high with s_valid |
| s_href | input | 1 | horizontal reference carried with the beat |
| s_vref | input | 1 | vertical reference carried with the beat |
| s_y | input | 12 | signed luma on the 10-bit scale, with over/undershoot |
| s_u | input | 8 | signed U sample |
| s_v | input | 8 | signed V sample |
| m_valid | output | 1 | output beat valid |
| m_ready | input | 1 | downstream ready |
| m_y | output | 10 | processed luma |
| m_u | output | 8 | processed U |
| m_v | output | 8 | processed V |
| cfg_sp_start | input | 10 | sidepanel start, units of 4 beats |
| cfg_sp_stop | input | 10 | sidepanel stop, units of 4 beats |
| cfg_sp_fine | input | 2 | fine offset 0..3 added to both sidepanel edges |
| cfg_sp_y | input | 10 | sidepanel luma |
| cfg_sp_u | input | 4 | sidepanel U upper nibble |
| cfg_sp_v | input | 4 | sidepanel V upper nibble |
| cfg_hb_set | input | 12 | horizontal blank window set position |
| cfg_hb_rst | input | 12 | horizontal blank window reset position |
| cfg_vb_set | input | 10 | vertical blank window set line |
| cfg_vb_rst | input | 10 | vertical blank window reset line |
| cfg_y9 | input | 1 | 1 selects the 9-bit nominal luma range |

## Verification
Every result is due exactly one cycle after the beat is accepted. Each accepted beat's expected output is computed from its beat and line index and the settings the bench last presented on a vertical edge beat. That value is queued at acceptance and compared on the first later cycle in which `m_valid` and `m_ready` are both high. This makes the checks independent of the random valid and ready gaps. Separate checks cover timing: `m_valid` must be high in the cycle after every acceptance, and outputs must be unchanged in the cycle after any stall. Settings change in the middle of each field, so every field also checks that the change waits for the next vertical edge.

// File: rtl/sbi_pkg.sv
package sbi_pkg;
  typedef enum logic [1:0] {
    PIX_PASS  = 2'd0,
    PIX_SIDE  = 2'd1,
    PIX_BLANK = 2'd2
  } pix_sel_e;

  localparam int BLANK_Y = 64;
  localparam int SP_NIB  = 4;
endpackage

// File: rtl/sbi_pos_track.sv
module sbi_pos_track #(
  parameter int PW = 12,
  parameter int LW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic          href,
  input  logic          vref,
  output logic          hrise,
  output logic          vrise,
  output logic [PW-1:0] pos_cur,
  output logic [LW-1:0] line_cur
);
  localparam logic [PW-1:0] PMAX = '1;
  localparam logic [LW-1:0] LMAX = '1;

  logic          href_q, vref_q;
  logic [PW-1:0] pos_q;
  logic [LW-1:0] line_q;

  assign hrise = href && !href_q;
  assign vrise = vref && !vref_q;

  always_comb begin
    if (hrise)              pos_cur = '0;
    else if (pos_q == PMAX) pos_cur = pos_q;
    else                    pos_cur = pos_q + 1'b1;
  end

  always_comb begin
    if (vrise)                       line_cur = '0;
    else if (hrise && line_q != LMAX) line_cur = line_q + 1'b1;
    else                             line_cur = line_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      href_q <= 1'b0;
      vref_q <= 1'b0;
      pos_q  <= '0;
      line_q <= '0;
    end else if (acc) begin
      href_q <= href;
      vref_q <= vref;
      pos_q  <= pos_cur;
      line_q <= line_cur;
    end
  end

  assert_hpos_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && hrise |=> pos_q == '0);
  assert_hpos_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !hrise && pos_q != PMAX |=> pos_q == $past(pos_q) + 1'b1);
  assert_line_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && vrise |=> line_q == '0);
  assert_line_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !hrise && !vrise |=> line_q == $past(line_q));
endmodule

// File: rtl/sbi_cfg_shadow.sv
module sbi_cfg_shadow #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         acc,
  input  logic         vrise,
  input  logic [W-1:0] cfg_in,
  output logic [W-1:0] cfg_eff
);
  logic [W-1:0] shadow_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            shadow_q <= '0;
    else if (acc && vrise) shadow_q <= cfg_in;
  end

  assign cfg_eff = vrise ? cfg_in : shadow_q;

  assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && vrise) |=> $stable(shadow_q));
  assert_shadow_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc && vrise |=> shadow_q == $past(cfg_in));
endmodule

// File: rtl/sbi_window.sv
module sbi_window #(
  parameter int W = 12
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] set_at,
  input  logic [W-1:0] rst_at,
  output logic         hit
);
  logic after_set, before_rst;

  assign after_set  = cnt >= set_at;
  assign before_rst = cnt < rst_at;

  always_comb begin
    if (set_at <= rst_at) hit = after_set && before_rst;
    else                  hit = after_set || before_rst;
  end
endmodule

// File: rtl/sbi_region.sv
module sbi_region
  import sbi_pkg::*;
#(
  parameter int PW = 12,
  parameter int LW = 10
) (
  input  logic [PW-1:0] pos,
  input  logic [LW-1:0] line,
  input  logic [PW-3:0] sp_start,
  input  logic [PW-3:0] sp_stop,
  input  logic [1:0]    sp_fine,
  input  logic [PW-1:0] hb_set,
  input  logic [PW-1:0] hb_rst,
  input  logic [LW-1:0] vb_set,
  input  logic [LW-1:0] vb_rst,
  output pix_sel_e      sel
);
  logic [PW-1:0] edge_s, edge_e;
  logic          h_hit, v_hit, side;

  assign edge_s = {sp_start, sp_fine};
  assign edge_e = {sp_stop, sp_fine};
  assign side   = (pos < edge_s) || (pos >= edge_e);

  sbi_window #(.W(PW)) u_hwin (
    .cnt(pos), .set_at(hb_set), .rst_at(hb_rst), .hit(h_hit)
  );

  sbi_window #(.W(LW)) u_vwin (
    .cnt(line), .set_at(vb_set), .rst_at(vb_rst), .hit(v_hit)
  );

  always_comb begin
    if (h_hit || v_hit) sel = PIX_BLANK;
    else if (side)      sel = PIX_SIDE;
    else                sel = PIX_PASS;
  end
endmodule

// File: rtl/sbi_pix_mux.sv
module sbi_pix_mux
  import sbi_pkg::*;
#(
  parameter int YIW = 12,
  parameter int YOW = 10,
  parameter int CW  = 8
) (
  input  pix_sel_e              sel,
  input  logic                  y9,
  input  logic signed [YIW-1:0] y_in,
  input  logic signed [CW-1:0]  u_in,
  input  logic signed [CW-1:0]  v_in,
  input  logic [YOW-1:0]        sp_y,
  input  logic [SP_NIB-1:0]     sp_u,
  input  logic [SP_NIB-1:0]     sp_v,
  output logic [YOW-1:0]        y_out,
  output logic [CW-1:0]         u_out,
  output logic [CW-1:0]         v_out
);
  localparam logic signed [YIW:0] OFS9 = (YIW+1)'(2 ** (YOW - 2));
  localparam logic signed [YIW:0] YTOP = (YIW+1)'(2 ** YOW - 1);

  logic signed [YIW:0] y_ext, y_half, y_adj;
  logic [YOW-1:0]      y_clip;

  always_comb begin
    y_ext  = {y_in[YIW-1], y_in};
    y_half = y_ext >>> 1;
    y_adj  = y9 ? (y_half + OFS9) : y_ext;
    if (y_adj < 0)         y_clip = '0;
    else if (y_adj > YTOP) y_clip = '1;
    else                   y_clip = y_adj[YOW-1:0];
  end

  always_comb begin
    unique case (sel)
      PIX_BLANK: begin
        y_out = YOW'(BLANK_Y);
        u_out = '0;
        v_out = '0;
      end
      PIX_SIDE: begin
        y_out = sp_y;
        u_out = {sp_u, {(CW-SP_NIB){1'b0}}};
        v_out = {sp_v, {(CW-SP_NIB){1'b0}}};
      end
      default: begin
        y_out = y_clip;
        u_out = u_in;
        v_out = v_in;
      end
    endcase
  end
endmodule

// File: rtl/sbi_top.sv
module sbi_top
  import sbi_pkg::*;
#(
  parameter int PW  = 12,
  parameter int LW  = 10,
  parameter int YIW = 12,
  parameter int YOW = 10,
  parameter int CW  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  s_valid,
  output logic                  s_ready,
  input  logic                  s_href,
  input  logic                  s_vref,
  input  logic signed [YIW-1:0] s_y,
  input  logic signed [CW-1:0]  s_u,
  input  logic signed [CW-1:0]  s_v,
  output logic                  m_valid,
  input  logic                  m_ready,
  output logic [YOW-1:0]        m_y,
  output logic [CW-1:0]         m_u,
  output logic [CW-1:0]         m_v,
  input  logic [PW-3:0]         cfg_sp_start,
  input  logic [PW-3:0]         cfg_sp_stop,
  input  logic [1:0]            cfg_sp_fine,
  input  logic [YOW-1:0]        cfg_sp_y,
  input  logic [SP_NIB-1:0]     cfg_sp_u,
  input  logic [SP_NIB-1:0]     cfg_sp_v,
  input  logic [PW-1:0]         cfg_hb_set,
  input  logic [PW-1:0]         cfg_hb_rst,
  input  logic [LW-1:0]         cfg_vb_set,
  input  logic [LW-1:0]         cfg_vb_rst,
  input  logic                  cfg_y9
);
  localparam int CFGW = 2*(PW-2) + 2 + YOW + 2*SP_NIB + 2*PW + 2*LW + 1;

  logic            acc, hrise, vrise;
  logic [PW-1:0]   pos;
  logic [LW-1:0]   line;
  logic [CFGW-1:0] cfg_in, cfg_eff;

  logic [PW-3:0]     a_sp_start, a_sp_stop;
  logic [1:0]        a_sp_fine;
  logic [YOW-1:0]    a_sp_y;
  logic [SP_NIB-1:0] a_sp_u, a_sp_v;
  logic [PW-1:0]     a_hb_set, a_hb_rst;
  logic [LW-1:0]     a_vb_set, a_vb_rst;
  logic              a_y9;

  pix_sel_e       sel;
  logic [YOW-1:0] y_nx;
  logic [CW-1:0]  u_nx, v_nx;

  assign s_ready = !m_valid || m_ready;
  assign acc     = s_valid && s_ready;

  sbi_pos_track #(.PW(PW), .LW(LW)) u_pos (
    .clk(clk), .rst_n(rst_n), .acc(acc), .href(s_href), .vref(s_vref),
    .hrise(hrise), .vrise(vrise), .pos_cur(pos), .line_cur(line)
  );

  assign cfg_in = {cfg_sp_start, cfg_sp_stop, cfg_sp_fine, cfg_sp_y, cfg_sp_u,
                   cfg_sp_v, cfg_hb_set, cfg_hb_rst, cfg_vb_set, cfg_vb_rst, cfg_y9};

  sbi_cfg_shadow #(.W(CFGW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .acc(acc), .vrise(vrise),
    .cfg_in(cfg_in), .cfg_eff(cfg_eff)
  );

  assign {a_sp_start, a_sp_stop, a_sp_fine, a_sp_y, a_sp_u, a_sp_v,
          a_hb_set, a_hb_rst, a_vb_set, a_vb_rst, a_y9} = cfg_eff;

  sbi_region #(.PW(PW), .LW(LW)) u_region (
    .pos(pos), .line(line), .sp_start(a_sp_start), .sp_stop(a_sp_stop),
    .sp_fine(a_sp_fine), .hb_set(a_hb_set), .hb_rst(a_hb_rst),
    .vb_set(a_vb_set), .vb_rst(a_vb_rst), .sel(sel)
  );

  sbi_pix_mux #(.YIW(YIW), .YOW(YOW), .CW(CW)) u_mux (
    .sel(sel), .y9(a_y9), .y_in(s_y), .u_in(s_u), .v_in(s_v),
    .sp_y(a_sp_y), .sp_u(a_sp_u), .sp_v(a_sp_v),
    .y_out(y_nx), .u_out(u_nx), .v_out(v_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       m_valid <= 1'b0;
    else if (s_ready) m_valid <= s_valid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_y <= '0;
      m_u <= '0;
      m_v <= '0;
    end else if (acc) begin
      m_y <= y_nx;
      m_u <= u_nx;
      m_v <= v_nx;
    end
  end

  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_y) && $stable(m_u) && $stable(m_v));
  assert_accept_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> m_valid);
  assert_blank_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && sel == PIX_BLANK |=> m_y == YOW'(BLANK_Y) && m_u == '0 && m_v == '0);
  assert_side_nibble_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && sel == PIX_SIDE |=> m_u[CW-SP_NIB-1:0] == '0 && m_v[CW-SP_NIB-1:0] == '0);
endmodule

// File: tb/test_sbi_top.sv
module test_sbi_top;
  localparam int LINE_LEN = 40;
  localparam int LINES    = 6;
  localparam int FIELDS   = 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n, s_valid, s_ready, s_href, s_vref;
  logic signed [11:0] s_y;
  logic signed [7:0]  s_u, s_v;
  logic              m_valid, m_ready;
  logic [9:0]        m_y;
  logic [7:0]        m_u, m_v;
  logic [9:0]        cfg_sp_start, cfg_sp_stop, cfg_sp_y, cfg_vb_set, cfg_vb_rst;
  logic [1:0]        cfg_sp_fine;
  logic [3:0]        cfg_sp_u, cfg_sp_v;
  logic [11:0]       cfg_hb_set, cfg_hb_rst;
  logic              cfg_y9;

  sbi_top i_sbi_top (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_href(s_href), .s_vref(s_vref), .s_y(s_y), .s_u(s_u), .s_v(s_v),
    .m_valid(m_valid), .m_ready(m_ready), .m_y(m_y), .m_u(m_u), .m_v(m_v),
    .cfg_sp_start(cfg_sp_start), .cfg_sp_stop(cfg_sp_stop), .cfg_sp_fine(cfg_sp_fine),
    .cfg_sp_y(cfg_sp_y), .cfg_sp_u(cfg_sp_u), .cfg_sp_v(cfg_sp_v),
    .cfg_hb_set(cfg_hb_set), .cfg_hb_rst(cfg_hb_rst),
    .cfg_vb_set(cfg_vb_set), .cfg_vb_rst(cfg_vb_rst), .cfg_y9(cfg_y9)
  );

  typedef struct {
    int st, sp, fn, sy, su, sv, hs, hr, vs, vr, y9;
  } cfg_t;

  int   tests = 0, fails = 0;
  bit   done = 1'b0;
  cfg_t cur, act;

  logic [9:0] q_y[$];
  logic [7:0] q_u[$], q_v[$];
  string      q_tag[$];

  function automatic cfg_t cfg_for(int f);
    cfg_t c;
    c.st = 1 + f % 3;  c.sp = 7 + f % 2;  c.fn = f % 4;
    c.sy = 100 + 50 * f; c.su = f % 16; c.sv = 15 - f % 16;
    if (f % 4 == 3)     begin c.hs = 20; c.hr = 20; end
    else if (f % 2 == 0) begin c.hs = 36; c.hr = 3;  end
    else                begin c.hs = 12; c.hr = 16; end
    if (f % 2 == 0) begin c.vs = 5; c.vr = 1; end
    else            begin c.vs = 2; c.vr = 3; end
    c.y9 = (f / 2) % 2;
    return c;
  endfunction

  task automatic drive_cfg(cfg_t c);
    cfg_sp_start = 10'(c.st); cfg_sp_stop = 10'(c.sp); cfg_sp_fine = 2'(c.fn);
    cfg_sp_y = 10'(c.sy); cfg_sp_u = 4'(c.su); cfg_sp_v = 4'(c.sv);
    cfg_hb_set = 12'(c.hs); cfg_hb_rst = 12'(c.hr);
    cfg_vb_set = 10'(c.vs); cfg_vb_rst = 10'(c.vr); cfg_y9 = c.y9[0];
  endtask

  function automatic bit in_win(int c, int a, int b);
    if (a <= b) return (c >= a) && (c < b);
    return (c >= a) || (c < b);
  endfunction

  // Expected output of one beat from R4..R10
  task automatic push_expect(int x, int l, int yv, logic [7:0] u, logic [7:0] v);
    int s_edge, e_edge, yy;
    bit blank, side;
    s_edge = act.st * 4 + act.fn;
    e_edge = act.sp * 4 + act.fn;
    side   = (x < s_edge) || (x >= e_edge);
    blank  = in_win(x, act.hs, act.hr) || in_win(l, act.vs, act.vr);
    if (blank) begin
      q_y.push_back(10'd64); q_u.push_back(8'd0); q_v.push_back(8'd0);
      q_tag.push_back((l >= 3) ? "R6 R5 R10" : "R6 R5 R3");
    end else if (side) begin
      q_y.push_back(10'(act.sy));
      q_u.push_back({4'(act.su), 4'd0}); q_v.push_back({4'(act.sv), 4'd0});
      q_tag.push_back((l >= 3) ? "R4 R10" : "R4 R3");
    end else begin
      yy = act.y9 ? ((yv >>> 1) + 256) : yv;
      if (yy < 0) yy = 0;
      if (yy > 1023) yy = 1023;
      q_y.push_back(10'(yy)); q_u.push_back(u); q_v.push_back(v);
      q_tag.push_back(act.y9 ? "R8 R9" : "R7 R9");
    end
  endtask

  task automatic check(bit ok, string req, int act_v, int exp_v);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act_v, exp_v, $time);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int f, l, x, g, yv;
    bit pend, stalled, fired_prev;
    logic [9:0] hy;
    logic [7:0] hu, hv;
    logic [7:0] uu, vv;
    rst_n = 1'b0; s_valid = 1'b0; m_ready = 1'b0;
    s_href = 1'b0; s_vref = 1'b0; s_y = '0; s_u = '0; s_v = '0;
    cur = cfg_for(0); act = cur; drive_cfg(cur);
    repeat (3) @(negedge clk);
    // R1: reset state
    check(m_valid == 1'b0, "R1 m_valid in reset", int'(m_valid), 0);
    check(s_ready == 1'b1, "R1 s_ready in reset", int'(s_ready), 1);
    rst_n = 1'b1;
    f = 0; l = 0; x = 0; g = 0;
    pend = 1'b0; stalled = 1'b0; fired_prev = 1'b0;
    hy = '0; hu = '0; hv = '0;
    while (f < FIELDS || q_y.size() != 0) begin
      @(negedge clk);
      yv = ((g * 53 + 11) % 4096) - 2048;
      uu = 8'(g * 7);
      vv = 8'(g * 13 + 5);
      if (f < FIELDS) begin
        s_valid = pend ? 1'b1 : (($urandom % 4) != 0);
        s_href  = (x < 2);
        s_vref  = (l == 0) && (x < 3);
        s_y = 12'(yv); s_u = uu; s_v = vv;
      end else begin
        s_valid = 1'b0;
      end
      m_ready = (($urandom % 3) != 0);
      #1;
      // R2: outputs held after a stall
      if (stalled) begin
        check(m_valid == 1'b1, "R2 valid held in stall", int'(m_valid), 1);
        check(m_y == hy && m_u == hu && m_v == hv, "R2 data held in stall", int'(m_y), int'(hy));
      end
      // R2: one-cycle latency
      if (fired_prev) check(m_valid == 1'b1, "R2 result due one cycle after accept", int'(m_valid), 1);
      check(s_ready == (!m_valid || m_ready), "R2 ready rule", int'(s_ready), int'(!m_valid || m_ready));
      stalled = m_valid && !m_ready;
      hy = m_y; hu = m_u; hv = m_v;
      if (m_valid && m_ready) begin
        if (q_y.size() == 0) begin
          check(1'b0, "R2 unexpected output beat", 1, 0);
        end else begin
          logic [9:0] ey;
          logic [7:0] eu, ev;
          string t;
          ey = q_y.pop_front(); eu = q_u.pop_front(); ev = q_v.pop_front(); t = q_tag.pop_front();
          check(m_y == ey, {t, " Y"}, int'(m_y), int'(ey));
          check(m_u == eu && m_v == ev, {t, " UV"}, int'({m_u, m_v}), int'({eu, ev}));
        end
      end
      fired_prev = s_valid && s_ready;
      pend = s_valid && !s_ready;
      if (s_valid && s_ready) begin
        if (l == 0 && x == 0) act = cur;   // R10 capture on vertical edge beat
        push_expect(x, l, yv, uu, vv);
        if (l == 3 && x == 0) begin        // R10 mid-field change, deferred
          cur = cfg_for(f + 1);
          drive_cfg(cur);
        end
        g++;
        x++;
        if (x == LINE_LEN) begin x = 0; l++; end
        if (l == LINES) begin l = 0; f++; end
      end
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule